// File: doc/BRIEF.md
# Display Coprocessor Pointer Unit

This block keeps the two program start addresses of a display coprocessor and the address the coprocessor fetches from next. Software writes each 32-bit start address as two 16-bit halves through a small register port. The port takes a word-aligned 9-bit offset, a valid strobe, a write flag and 16-bit write data. Two further offsets act as restart triggers: any access to one of them, read or write, moves the fetch pointer to the matching start address.

The raster generator raises `frame_start` for one cycle when its line counter wraps to zero, and the pointer then reloads from the first start address. The instruction engine, which is outside this block, raises `ptr_advance` each time it consumes a 16-bit word, and the pointer then moves forward by two bytes. Every update takes effect on the clock edge that samples the request.

Top module: `dcop_ptr_unit`

## Requirements
- R1: After an active-low reset, `fetch_ptr` reads 0 and both start addresses hold 0.
- R2: A write (valid=1, write=1) to offset 0x080 loads bits 31:16 of start address A from the write data and leaves bits 15:0 of A unchanged.
- R3: A write to offset 0x082 loads bits 15:0 of start address A and leaves bits 31:16 unchanged.
- R4: Writes to offsets 0x084 and 0x086 load the high and low halves of start address B in the same way.
- R5: Any valid access, read or write, to offset 0x088 sets `fetch_ptr` to start address A one cycle later, using the value A held before that edge.
- R6: Any valid access, read or write, to offset 0x08A sets `fetch_ptr` to start address B one cycle later.
- R7: `frame_start` high sets `fetch_ptr` to start address A one cycle later.
- R8: When a restart access and `frame_start` occur in the same cycle, the restart access decides the new pointer.
- R9: `ptr_advance` high adds 2 to `fetch_ptr`, wrapping modulo 2^32. It is ignored in any cycle where a restart access or `frame_start` reloads the pointer.
- R10: `acc_rdata` is 0 for every read. Reads of offsets 0x080 to 0x086 leave both start addresses unchanged.
- R11: Accesses with valid=0, accesses to odd offsets and accesses to any offset other than 0x080 to 0x08A change neither the start addresses nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 9 | Byte offset of the accessed register (bit 0 must be 0) |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data (always 0) |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| ptr_advance | input | 1 | Step the fetch pointer by one word |
| fetch_ptr | output | 32 | Current coprocessor fetch address |

## Verification
The bench loads each address half separately and then restarts the pointer from it. A design that overwrote the other half on a half-write would show a wrong pointer after the restart. The bench also triggers restarts with read accesses, so a decoder that only looked at writes would leave the pointer where it was. It collides a restart access with `frame_start`, and each of them with `ptr_advance`, so a design that got the priority wrong would load the wrong address or land two bytes off. A further run steps the pointer across the 32-bit wrap. The bench sends reads, odd offsets and idle cycles that carry write data, which would expose a start register that loaded without checking the write flag.

// File: rtl/dcop_pkg.sv
// Shared definitions for the display coprocessor pointer unit.
// Assumes two start locations whose register offsets sit at fixed spacing.
package dcop_pkg;
    localparam int DCOP_HALF_W   = 16;
    localparam int DCOP_OFS_W    = 9;
    localparam int DCOP_NUM_LOC  = 2;
    localparam logic [DCOP_OFS_W-1:0] DCOP_LOC_BASE    = 9'h080;
    localparam logic [DCOP_OFS_W-1:0] DCOP_STROBE_BASE = 9'h088;

    // Source chosen for the next fetch pointer value.
    typedef enum logic [1:0] {
        PSRC_HOLD   = 2'd0,
        PSRC_STROBE = 2'd1,
        PSRC_FRAME  = 2'd2,
        PSRC_STEP   = 2'd3
    } ptr_src_e;
endpackage

// File: rtl/dcop_reg_decode.sv
// Decodes register port accesses into per-location half-load enables and a
// restart request with the index of its location.
// Assumes NUM_LOC >= 2. Location i has its high half at LOC_BASE+4i, its low
// half at LOC_BASE+4i+2 and its restart trigger at STROBE_BASE+2i.
module dcop_reg_decode #(
    parameter int OFS_W = 9,
    parameter int NUM_LOC = 2,
    parameter logic [OFS_W-1:0] LOC_BASE = 9'h080,
    parameter logic [OFS_W-1:0] STROBE_BASE = 9'h088,
    localparam int IDX_W = $clog2(NUM_LOC)
) (
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [OFS_W-1:0]   acc_offset,
    output logic [NUM_LOC-1:0] load_hi,
    output logic [NUM_LOC-1:0] load_lo,
    output logic               restart_any,
    output logic [IDX_W-1:0]   restart_idx
);
    logic [NUM_LOC-1:0] restart_hit;

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        localparam logic [OFS_W-1:0] HI_OFS = LOC_BASE + OFS_W'(4 * i);
        localparam logic [OFS_W-1:0] LO_OFS = LOC_BASE + OFS_W'(4 * i + 2);
        localparam logic [OFS_W-1:0] RS_OFS = STROBE_BASE + OFS_W'(2 * i);
        // Half-load enables are for writes only.
        assign load_hi[i] = acc_valid && acc_write && (acc_offset == HI_OFS);
        assign load_lo[i] = acc_valid && acc_write && (acc_offset == LO_OFS);
        // A restart fires on reads and on writes.
        assign restart_hit[i] = acc_valid && (acc_offset == RS_OFS);
    end

    // Turns the one-hot restart hit into a flag and an index.
    always_comb begin
        restart_any = |restart_hit;
        restart_idx = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (restart_hit[i]) restart_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dcop_start_reg.sv
// One start-address register, loaded as separate high and low halves.
// Assumes only one half is loaded per cycle; the decoder guarantees this.
module dcop_start_reg #(
    parameter int HALF_W = 16,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [HALF_W-1:0] wdata,
    output logic [FULL_W-1:0] addr
);
    // Updates the addressed half and keeps the other one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else begin
            if (load_hi) addr[FULL_W-1:HALF_W] <= wdata;
            if (load_lo) addr[HALF_W-1:0]      <= wdata;
        end
    end
endmodule

// File: rtl/dcop_fetch_ptr.sv
// Fetch pointer register. Priority: restart access, then frame start, then
// word step. Assumes restart_addr already holds the selected location.
module dcop_fetch_ptr #(
    parameter int PTR_W = 32,
    parameter int STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_any,
    input  logic [PTR_W-1:0] restart_addr,
    input  logic             frame_start,
    input  logic [PTR_W-1:0] first_addr,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr
);
    import dcop_pkg::*;

    ptr_src_e src;

    // Picks the winning update source for this cycle.
    always_comb begin
        if (restart_any)      src = PSRC_STROBE;
        else if (frame_start) src = PSRC_FRAME;
        else if (advance)     src = PSRC_STEP;
        else                  src = PSRC_HOLD;
    end

    // Applies the chosen update to the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (src)
                PSRC_STROBE: ptr <= restart_addr;
                PSRC_FRAME:  ptr <= first_addr;
                PSRC_STEP:   ptr <= ptr + PTR_W'(STEP);
                default:     ptr <= ptr;
            endcase
        end
    end
endmodule

// File: rtl/dcop_ptr_unit.sv
// Top of the display coprocessor pointer unit: start-address registers,
// access decoding and the fetch pointer.
// Assumes word-aligned accesses; the registers are write-only, so reads return 0.
module dcop_ptr_unit #(
    parameter int HALF_W = dcop_pkg::DCOP_HALF_W,
    parameter int OFS_W = dcop_pkg::DCOP_OFS_W,
    parameter int NUM_LOC = dcop_pkg::DCOP_NUM_LOC,
    parameter logic [OFS_W-1:0] LOC_BASE = dcop_pkg::DCOP_LOC_BASE,
    parameter logic [OFS_W-1:0] STROBE_BASE = dcop_pkg::DCOP_STROBE_BASE,
    localparam int PTR_W = 2 * HALF_W,
    localparam int IDX_W = $clog2(NUM_LOC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_offset,
    input  logic [HALF_W-1:0] acc_wdata,
    output logic [HALF_W-1:0] acc_rdata,
    input  logic              frame_start,
    input  logic              ptr_advance,
    output logic [PTR_W-1:0]  fetch_ptr
);
    logic [NUM_LOC-1:0] load_hi;
    logic [NUM_LOC-1:0] load_lo;
    logic               restart_any;
    logic [IDX_W-1:0]   restart_idx;
    logic [PTR_W-1:0]   start_addr [NUM_LOC];
    logic [PTR_W-1:0]   restart_addr;

    dcop_reg_decode #(
        .OFS_W(OFS_W), .NUM_LOC(NUM_LOC),
        .LOC_BASE(LOC_BASE), .STROBE_BASE(STROBE_BASE)
    ) u_decode (
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
        .load_hi(load_hi), .load_lo(load_lo),
        .restart_any(restart_any), .restart_idx(restart_idx)
    );

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_start
        dcop_start_reg #(.HALF_W(HALF_W)) u_start (
            .clk(clk), .rst_n(rst_n),
            .load_hi(load_hi[i]), .load_lo(load_lo[i]),
            .wdata(acc_wdata), .addr(start_addr[i])
        );
    end

    // Routes the location named by the restart access to the pointer.
    always_comb restart_addr = start_addr[restart_idx];

    dcop_fetch_ptr #(.PTR_W(PTR_W), .STEP(HALF_W / 8)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .restart_any(restart_any), .restart_addr(restart_addr),
        .frame_start(frame_start), .first_addr(start_addr[0]),
        .advance(ptr_advance), .ptr(fetch_ptr)
    );

    // The start-address registers are write-only; reads return 0.
    assign acc_rdata = '0;
endmodule

// File: rtl/dcop_ptr_unit_chk.sv
// Temporal checks on the pointer unit, attached to the top by bind.
// Assumes the default offset layout (0x080 to 0x08A).
module dcop_ptr_unit_chk #(
    parameter int PTR_W = 32,
    parameter int OFS_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [OFS_W-1:0]   acc_offset,
    input logic [PTR_W/2-1:0] acc_wdata,
    input logic               frame_start,
    input logic               ptr_advance,
    input logic [PTR_W-1:0]   fetch_ptr,
    input logic [PTR_W-1:0]   first_addr,
    input logic [PTR_W-1:0]   second_addr
);
    localparam int H = PTR_W / 2;
    logic strobe_a, strobe_b;
    assign strobe_a = acc_valid && (acc_offset == OFS_W'('h088));
    assign strobe_b = acc_valid && (acc_offset == OFS_W'('h08A));

    a_r2_high_half_load: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_offset == OFS_W'('h080) |=>
        first_addr[PTR_W-1:H] == $past(acc_wdata) && first_addr[H-1:0] == $past(first_addr[H-1:0]));

    a_r3_low_half_load: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_offset == OFS_W'('h082) |=>
        first_addr[H-1:0] == $past(acc_wdata) && first_addr[PTR_W-1:H] == $past(first_addr[PTR_W-1:H]));

    a_r5_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_a |=> fetch_ptr == $past(first_addr));

    a_r6_restart_second: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_b |=> fetch_ptr == $past(second_addr));

    a_r7_frame_reload: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !strobe_a && !strobe_b |=> fetch_ptr == $past(first_addr));

    a_r9_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_advance && !frame_start && !strobe_a && !strobe_b |=>
        fetch_ptr == $past(fetch_ptr) + PTR_W'(2));

    a_r10_read_keeps_starts: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> $stable(first_addr) && $stable(second_addr));

    a_r11_idle_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid && !frame_start && !ptr_advance |=> $stable(fetch_ptr));
endmodule

bind dcop_ptr_unit dcop_ptr_unit_chk #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .frame_start(frame_start),
    .ptr_advance(ptr_advance), .fetch_ptr(fetch_ptr),
    .first_addr(start_addr[0]), .second_addr(start_addr[1])
);

// File: tb/dcop_ptr_unit_test.sv
module dcop_ptr_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [8:0]  acc_offset = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        frame_start = 1'b0, ptr_advance = 1'b0;
    logic [31:0] fetch_ptr;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] ref_a = '0, ref_b = '0, ref_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcop_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .frame_start(frame_start), .ptr_advance(ptr_advance), .fetch_ptr(fetch_ptr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h, expected %08h", req, act, exp);
        end
    endtask

    // Reference model: the next state from the inputs sampled at this edge.
    task automatic model_step();
        logic [31:0] a0 = ref_a, b0 = ref_b, nxt = ref_ptr;
        if (acc_valid && acc_offset == 9'h088)      nxt = a0;
        else if (acc_valid && acc_offset == 9'h08A) nxt = b0;
        else if (frame_start)                       nxt = a0;
        else if (ptr_advance)                       nxt = ref_ptr + 32'd2;
        if (acc_valid && acc_write) begin
            case (acc_offset)
                9'h080: ref_a[31:16] = acc_wdata;
                9'h082: ref_a[15:0]  = acc_wdata;
                9'h084: ref_b[31:16] = acc_wdata;
                9'h086: ref_b[15:0]  = acc_wdata;
                default: ;
            endcase
        end
        ref_ptr = nxt;
    endtask

    // One cycle: drive at negedge, update the model at posedge, compare at the next negedge.
    task automatic cyc(input logic v, input logic w, input logic [8:0] ofs, input logic [15:0] d,
                       input logic fs, input logic adv, input string req);
        acc_valid = v; acc_write = w; acc_offset = ofs; acc_wdata = d;
        frame_start = fs; ptr_advance = adv;
        #1;
        if (v && !w) check({req, " R10 rdata"}, {16'h0, acc_rdata}, 32'h0);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req, fetch_ptr, ref_ptr);
    endtask

    task automatic idle(input string req);
        cyc(1'b0, 1'b0, 9'h000, 16'h0, 1'b0, 1'b0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset ptr", fetch_ptr, 32'h0);
        // R9: word steps from reset
        cyc(0, 0, 9'h000, 16'h0, 0, 1, "R9 step");
        cyc(0, 0, 9'h000, 16'h0, 0, 1, "R9 step");
        check("R9 two steps", fetch_ptr, 32'h4);
        // R1: start address A is zero after reset
        cyc(1, 0, 9'h088, 16'h0, 0, 0, "R1 start A zero");
        cyc(1, 1, 9'h08A, 16'h0, 0, 0, "R1 start B zero");
        // R2/R3: half loads
        cyc(1, 1, 9'h080, 16'h1234, 0, 0, "R2 write hi");
        cyc(1, 1, 9'h088, 16'h0, 0, 0, "R2 restart A");
        check("R2 hi only", fetch_ptr, 32'h1234_0000);
        cyc(1, 1, 9'h082, 16'hABCE, 0, 0, "R3 write lo");
        cyc(1, 0, 9'h088, 16'h0, 0, 0, "R5 read restart A");
        check("R3 lo loaded", fetch_ptr, 32'h1234_ABCE);
        cyc(1, 1, 9'h080, 16'h5555, 0, 0, "R2 rewrite hi");
        cyc(0, 0, 9'h000, 16'h0, 0, 1, "R9 step");
        cyc(1, 1, 9'h088, 16'h0, 0, 0, "R2 restart A");
        check("R2 lo kept", fetch_ptr, 32'h5555_ABCE);
        // R4/R6: location B
        cyc(1, 1, 9'h084, 16'hCAFE, 0, 0, "R4 write B hi");
        cyc(1, 1, 9'h086, 16'h0010, 0, 0, "R4 write B lo");
        cyc(1, 0, 9'h08A, 16'h0, 0, 0, "R6 read restart B");
        check("R6 restart B", fetch_ptr, 32'hCAFE_0010);
        // R7: frame reload
        cyc(0, 0, 9'h000, 16'h0, 1, 0, "R7 frame");
        check("R7 frame reload", fetch_ptr, 32'h5555_ABCE);
        // R8: restart beats frame
        cyc(1, 1, 9'h08A, 16'h0, 1, 0, "R8 strobe vs frame");
        check("R8 strobe wins", fetch_ptr, 32'hCAFE_0010);
        // R9: reloads beat the step
        cyc(1, 0, 9'h088, 16'h0, 0, 1, "R9 strobe vs step");
        check("R9 strobe over step", fetch_ptr, 32'h5555_ABCE);
        cyc(1, 0, 9'h08A, 16'h0, 0, 0, "R6 restart B");
        cyc(0, 0, 9'h000, 16'h0, 1, 1, "R9 frame vs step");
        check("R9 frame over step", fetch_ptr, 32'h5555_ABCE);
        // R9: wrap across 2^32
        cyc(1, 1, 9'h080, 16'hFFFF, 0, 0, "R9 wrap setup");
        cyc(1, 1, 9'h082, 16'hFFFE, 0, 0, "R9 wrap setup");
        cyc(1, 1, 9'h088, 16'h0, 0, 0, "R9 wrap setup");
        cyc(0, 0, 9'h000, 16'h0, 0, 1, "R9 wrap");
        check("R9 wrap to zero", fetch_ptr, 32'h0);
        // R10: reads of the start offsets change nothing
        cyc(1, 0, 9'h080, 16'h9999, 0, 0, "R10 read A hi");
        cyc(1, 0, 9'h082, 16'h9999, 0, 0, "R10 read A lo");
        cyc(1, 0, 9'h084, 16'h9999, 0, 0, "R10 read B hi");
        cyc(1, 0, 9'h086, 16'h9999, 0, 0, "R10 read B lo");
        cyc(1, 1, 9'h088, 16'h0, 0, 0, "R10 restart A");
        check("R10 A unchanged", fetch_ptr, 32'hFFFF_FFFE);
        cyc(1, 1, 9'h08A, 16'h0, 0, 0, "R10 restart B");
        check("R10 B unchanged", fetch_ptr, 32'hCAFE_0010);
        // R11: invalid, odd and foreign offsets do nothing
        cyc(0, 1, 9'h080, 16'h7777, 0, 0, "R11 valid low");
        cyc(0, 1, 9'h088, 16'h7777, 0, 0, "R11 valid low strobe");
        check("R11 ptr held", fetch_ptr, 32'hCAFE_0010);
        cyc(1, 1, 9'h081, 16'h7777, 0, 0, "R11 odd offset");
        cyc(1, 1, 9'h089, 16'h7777, 0, 0, "R11 odd strobe");
        cyc(1, 1, 9'h08C, 16'h7777, 0, 0, "R11 foreign offset");
        cyc(1, 1, 9'h180, 16'h7777, 0, 0, "R11 foreign offset");
        check("R11 ptr held", fetch_ptr, 32'hCAFE_0010);
        cyc(1, 0, 9'h088, 16'h0, 0, 0, "R11 restart A");
        check("R11 A unchanged", fetch_ptr, 32'hFFFF_FFFE);
        idle("R11 idle");
        // Mixed stimulus against the model on every clock
        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic [8:0] ofs;
            case ($urandom_range(0, 9))
                0: ofs = 9'h080; 1: ofs = 9'h082; 2: ofs = 9'h084; 3: ofs = 9'h086;
                4, 5: ofs = 9'h088; 6: ofs = 9'h08A; 7: ofs = 9'h08C;
                8: ofs = 9'h087; default: ofs = 9'(($urandom_range(0, 255)) * 2);
            endcase
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, ofs,
                16'($urandom()), $urandom_range(0, 19) == 0, $urandom_range(0, 4) < 2,
                "R5 R6 R7 R8 R9 mixed");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule